// File: doc/BRIEF.md
# Activity Monitor Counter Bank

The block holds five 64-bit activity counters. Each one has a dedicated event input and adds one for every cycle in which that input is high. Counter 0 counts core cycles. It stops while the core sits in a wait-for-interrupt or wait-for-event low-power state. Counters 1 to 4 count whether or not the core is in such a state.

The counters can be reached in two ways. A 64-bit system-register port reads any counter. It can also load a counter, but only when the requester runs at the top privilege level. An external 32-bit memory-mapped port reads one half of a counter per access and never changes any counter. The block is placed next to the core. The event sources, the bus fabric and the trap logic stay outside it.

Top module: `act_mon_bank`

## Requirements
- R1: There are five counters of 64 bits each. All of them hold zero after the asynchronous active-low reset.
- R2: Counter n adds one at the clock edge where `evt_i[n]` is high, so the new value shows on the read ports in the cycle that follows.
- R3: While `low_pwr_i` is high, counter 0 ignores its event. Counters 1 to 4 keep counting.
- R4: A counter holding all ones wraps to zero on its next increment, with no other indication.
- R5: When `sys_we_i` is high and `sys_el_i` is 2'b11, `sys_wdata_i` is loaded into the counter chosen by `sys_sel_i` (values 0 to 4) at the next edge. A selector value of 5 to 7 changes no counter.
- R6: When `sys_el_i` is 2'b00, 2'b01 or 2'b10, a system-register write changes no counter.
- R7: When an accepted write and an event reach the same counter in the same cycle, the counter takes the written value.
- R8: `sys_rdata_o` shows the counter selected by `sys_sel_i` in the same cycle. It is zero for selector values 5 to 7.
- R9: An external read with `ext_req_i` high and `ext_we_i` low returns bits [31:0] of counter n at byte offset 8n and bits [63:32] at offset 8n+4, in the same cycle, with `ext_err_o` low. With `ext_req_i` low, both `ext_rdata_o` and `ext_err_o` are zero.
- R10: An external read at an offset of 0x28 or above, or at an offset whose bits [1:0] are not zero, returns zero with `ext_err_o` high.
- R11: An external write returns zero with `ext_err_o` high and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event pulse for each counter |
| low_pwr_i | input | 1 | Core is in a wait-for-interrupt or wait-for-event state |
| sys_we_i | input | 1 | System-register write request |
| sys_el_i | input | 2 | Privilege level of the requester (3 is highest) |
| sys_sel_i | input | 3 | Counter index for system-register read and write |
| sys_wdata_i | input | 64 | System-register write data |
| sys_rdata_o | output | 64 | Selected counter value |
| ext_req_i | input | 1 | External access valid |
| ext_we_i | input | 1 | External access is a write |
| ext_addr_i | input | 8 | External byte offset |
| ext_rdata_o | output | 32 | External read data |
| ext_err_o | output | 1 | External error response |

## Verification
A wrong count, a missed gate or a lost write stays in a register until something reads it. The bench therefore reads the selected counter through both ports on every cycle and compares it with a behavioural model. It also sweeps all five counters through both ports after each phase, so a fault shows at the ports no later than the next sweep. Wrong decoding of an offset or of a half shows at once on `ext_rdata_o` and `ext_err_o`, because the external port has no state.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int NUM_CNT = 5;
  localparam int CNT_W   = 64;
  localparam int EL_W    = 2;
  localparam logic [EL_W-1:0] EL_TOP = 2'd3;
  localparam int EXT_DW  = 32;
  localparam int EXT_AW  = 8;
  localparam int SEL_W   = $clog2(NUM_CNT);
endpackage

// File: rtl/amu_counter.sv
module amu_counter #(
  parameter int CNT_W = 64,
  parameter bit GATED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             idle_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic inc;
  assign inc = evt_i && !(GATED && idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (wr_i) cnt_o <= wdata_i;
    else if (inc)  cnt_o <= cnt_o + 1'b1;
  end

  p_write_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i && !idle_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  p_no_event_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !evt_i) |=> $stable(cnt_o));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i && !idle_i && (&cnt_o)) |=> cnt_o == '0);

  if (GATED) begin : g_gate_chk
    p_idle_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && idle_i) |=> $stable(cnt_o));
  end else begin : g_free_chk
    p_idle_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && idle_i && evt_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  end
endmodule

// File: rtl/amu_ext_port.sv
module amu_ext_port
  import amu_pkg::*;
#(
  parameter int N  = NUM_CNT,
  parameter int CW = CNT_W,
  parameter int DW = EXT_DW,
  parameter int AW = EXT_AW
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [N-1:0][CW-1:0]  cnt_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  err_o
);
  localparam int IDX_LSB = 3;

  logic hit;
  logic [DW-1:0] pick;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(addr_i[AW-1:IDX_LSB]) == i) begin
        hit  = 1'b1;
        pick = addr_i[2] ? cnt_i[i][2*DW-1:DW] : cnt_i[i][DW-1:0];
      end
    end
  end

  // unmapped, misaligned and any write are rejected
  always_comb begin
    err_o   = req_i && (we_i || !hit || (addr_i[1:0] != 2'b00));
    rdata_o = (req_i && !err_o) ? pick : '0;
  end

  always_comb begin
    a_err_zero_r10: assert (!err_o || rdata_o == '0);
    a_idle_quiet_r9: assert (req_i || (!err_o && rdata_o == '0));
  end
endmodule

// File: rtl/act_mon_bank.sv
module act_mon_bank
  import amu_pkg::*;
#(
  parameter int N  = NUM_CNT,
  parameter int CW = CNT_W,
  parameter int DW = EXT_DW,
  parameter int AW = EXT_AW,
  parameter int SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic          low_pwr_i,
  input  logic          sys_we_i,
  input  logic [EL_W-1:0] sys_el_i,
  input  logic [SW-1:0] sys_sel_i,
  input  logic [CW-1:0] sys_wdata_i,
  output logic [CW-1:0] sys_rdata_o,
  input  logic          ext_req_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic [DW-1:0] ext_rdata_o,
  output logic          ext_err_o
);
  logic [N-1:0][CW-1:0] cnt;
  logic [N-1:0]         wr_en;
  logic                 wr_ok;

  assign wr_ok = sys_we_i && (sys_el_i == EL_TOP);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    assign wr_en[i] = wr_ok && (sys_sel_i == SW'(i));

    amu_counter #(.CNT_W(CW), .GATED(i == 0)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[i]),
      .idle_i (low_pwr_i),
      .wr_i   (wr_en[i]),
      .wdata_i(sys_wdata_i),
      .cnt_o  (cnt[i])
    );

    p_unpriv_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sys_we_i && sys_el_i != EL_TOP && !evt_i[i]) |=> $stable(cnt[i]));
  end

  always_comb begin
    sys_rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (int'(sys_sel_i) == i) sys_rdata_o = cnt[i];
  end

  amu_ext_port #(.N(N), .CW(CW), .DW(DW), .AW(AW)) u_ext (
    .req_i  (ext_req_i),
    .we_i   (ext_we_i),
    .addr_i (ext_addr_i),
    .cnt_i  (cnt),
    .rdata_o(ext_rdata_o),
    .err_o  (ext_err_o)
  );

  p_reset_zero_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cnt == '0));
  p_wr_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  p_bad_sel_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sys_sel_i) >= N) |-> sys_rdata_o == '0);
endmodule

// File: tb/act_mon_bank_tb_top.sv
module act_mon_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt = '0;
  logic        lp = 1'b0;
  logic        swe = 1'b0;
  logic [1:0]  sel_el = 2'd0;
  logic [2:0]  ssel = '0;
  logic [63:0] swd = '0;
  logic [63:0] srd;
  logic        ereq = 1'b0;
  logic        ewe = 1'b0;
  logic [7:0]  eaddr = '0;
  logic [31:0] erd;
  logic        eerr;

  longint unsigned mdl [5];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  act_mon_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .low_pwr_i(lp),
    .sys_we_i(swe), .sys_el_i(sel_el), .sys_sel_i(ssel), .sys_wdata_i(swd),
    .sys_rdata_o(srd), .ext_req_i(ereq), .ext_we_i(ewe), .ext_addr_i(eaddr),
    .ext_rdata_o(erd), .ext_err_o(eerr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sys_exp(logic [2:0] s);
    return (s < 5) ? mdl[s] : 64'd0;
  endfunction

  task automatic ext_check(string req);
    logic [31:0] d = '0;
    logic e = 1'b0;
    if (ereq) begin
      if (ewe || eaddr[1:0] != 0 || eaddr >= 8'h28) e = 1'b1;
      else d = eaddr[2] ? mdl[eaddr[7:3]][63:32] : mdl[eaddr[7:3]][31:0];
    end
    check({req, " ext data"}, {32'd0, erd}, {32'd0, d});
    check({req, " ext err"}, {63'd0, eerr}, {63'd0, e});
  endtask

  // drive at negedge, check combinational reads, then update model at posedge
  task automatic step(string req, logic [4:0] ev, logic l, logic we, logic [1:0] el,
                      logic [2:0] s, logic [63:0] wd, logic rq, logic ew, logic [7:0] ad);
    evt = ev; lp = l; swe = we; sel_el = el; ssel = s; swd = wd;
    ereq = rq; ewe = ew; eaddr = ad;
    #1;
    check({req, " sys read"}, srd, sys_exp(s));
    ext_check(req);
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      if (we && el == 2'd3 && s == i) mdl[i] = wd;
      else if (ev[i] && !(i == 0 && l)) mdl[i] = mdl[i] + 1;
    end
    @(negedge clk);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 5; i++) begin
      step(req, 5'd0, 1'b0, 1'b0, 2'd0, 3'(i), 64'd0, 1'b1, 1'b0, 8'(8*i));
      step(req, 5'd0, 1'b0, 1'b0, 2'd0, 3'(i), 64'd0, 1'b1, 1'b0, 8'(8*i+4));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 reset zero");
    // R2 plain counting, several patterns
    for (int k = 0; k < 40; k++)
      step("R2 count", 5'((k * 7 + 3) ^ (k >> 1)), 1'b0, 1'b0, 2'd0, 3'(k % 5), 64'd0,
           1'b1, 1'b0, 8'(8 * (k % 5) + 4 * (k & 1)));
    sweep("R2 sweep");
    // R3 gating of counter 0 only
    for (int k = 0; k < 20; k++)
      step("R3 low power", 5'h1F, 1'b1, 1'b0, 2'd0, 3'(k % 5), 64'd0, 1'b0, 1'b0, 8'd0);
    sweep("R3 sweep");
    // R5 privileged write, R4 wrap
    step("R5 write", 5'd0, 1'b0, 1'b1, 2'd3, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 8'd0);
    step("R4 wrap", 5'b00100, 1'b0, 1'b0, 2'd0, 3'd2, 64'd0, 1'b1, 1'b0, 8'h14);
    step("R4 after wrap", 5'd0, 1'b0, 1'b0, 2'd0, 3'd2, 64'd0, 1'b1, 1'b0, 8'h10);
    step("R5 write hi", 5'd0, 1'b0, 1'b1, 2'd3, 3'd4, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 8'd0);
    step("R5 write c0", 5'd0, 1'b1, 1'b1, 2'd3, 3'd0, 64'hFFFF_FFFF_0000_0005, 1'b0, 1'b0, 8'd0);
    step("R5 bad sel write", 5'd0, 1'b0, 1'b1, 2'd3, 3'd5, 64'hDEAD, 1'b0, 1'b0, 8'd0);
    step("R5 bad sel write", 5'd0, 1'b0, 1'b1, 2'd3, 3'd7, 64'hBEEF, 1'b0, 1'b0, 8'd0);
    sweep("R5 sweep");
    // R6 lower privilege writes ignored
    for (int el = 0; el < 3; el++)
      for (int s = 0; s < 5; s++)
        step("R6 unpriv write", 5'd0, 1'b0, 1'b1, 2'(el), 3'(s), 64'hAAAA_5555, 1'b0, 1'b0, 8'd0);
    sweep("R6 sweep");
    // R7 write beats event
    step("R7 collide", 5'h1F, 1'b0, 1'b1, 2'd3, 3'd1, 64'd100, 1'b0, 1'b0, 8'd0);
    step("R7 collide", 5'h1F, 1'b0, 1'b1, 2'd3, 3'd0, 64'd7, 1'b0, 1'b0, 8'd0);
    sweep("R7 sweep");
    // R8 out-of-range selector reads zero
    for (int s = 5; s < 8; s++)
      step("R8 bad sel read", 5'd0, 1'b0, 1'b0, 2'd0, 3'(s), 64'd0, 1'b0, 1'b0, 8'd0);
    // R9/R10 full offset sweep
    for (int a = 0; a < 256; a++)
      step((a < 40 && a % 4 == 0) ? "R9 ext map" : "R10 ext unmapped",
           5'(a), a[0], 1'b0, 2'd0, 3'(a % 5), 64'd0, 1'b1, 1'b0, 8'(a));
    step("R9 no request", 5'd0, 1'b0, 1'b0, 2'd0, 3'd0, 64'd0, 1'b0, 1'b0, 8'h04);
    // R11 external writes rejected
    for (int a = 0; a < 40; a += 4)
      step("R11 ext write", 5'd0, 1'b0, 1'b0, 2'd0, 3'd0, 64'd0, 1'b1, 1'b1, 8'(a));
    sweep("R11 sweep");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule